// File: doc/BRIEF.md
# Week-Day-Time Real-Time Counter

This block keeps elapsed time as a set of counters for seconds, minutes, hours, day of the week and a count of elapsed weeks. A prescaler produces a one-second step. It counts either pulses of a subclock tick (32768 pulses per second by default) or cycles of the main clock. Each second step feeds a cascaded chain. When a field wraps, it carries into the next field. A week count of up to 4095 replaces any month or year calendar.

Software sets each field through a single write port and reads any field back through a select-driven read port. Any write restarts the one-second period. The block can also run as an interval timer clocked by the main clock. In that mode it raises a periodic interrupt pulse from a programmable reload count, and the time fields hold their values.

Top module: `weektime_counter`

## Requirements
- R1: With `src_main`=0, one second passes after every SUB_DIV high cycles of `sub_tick`; clock cycles without a tick do not advance the prescaler.
- R2: With `src_main`=1, one second passes every MAIN_DIV cycles of `clk`.
- R3: Seconds and minutes wrap from 59 to 0, hours wrap from 23 to 0 and the day field wraps from 6 to 0. Each wrap advances the next field by one in the same cycle.
- R4: The week field holds 0 to 4095. A carry at 4095 wraps it to 0 and sets `week_ovf`. The flag stays set until reset or a write to the week field.
- R5: A cycle with `wr_en`=1 loads `wr_data` into the field chosen by `wr_sel` (0 seconds, 1 minutes, 2 hours, 3 day, 4 week). A value above the field's maximum loads 0.
- R6: Any write clears the prescaler and the interval count. No second passes in a write cycle, and the next second comes one full period after the write.
- R7: In time mode, `tick_irq` is high for exactly one cycle, in the same cycle that an advanced time value first appears.
- R8: With `ivl_mode`=1, `tick_irq` pulses once every `ivl_reload` clock cycles (a reload of 0 acts as 1) and the time fields hold.
- R9: With `run_en`=0, no field, prescaler or interval count advances and `tick_irq` stays low.
- R10: After reset, every field reads 0 and `tick_irq` and `week_ovf` are low.
- R11: `rd_data` shows the field chosen by `rd_sel` (same encoding as `wr_sel`), zero-extended. Codes 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counting enable |
| src_main | input | 1 | 1: second derived from main clock, 0: from subclock tick |
| sub_tick | input | 1 | Subclock tick, one clk cycle high per subclock period |
| ivl_mode | input | 1 | 1: interval-timer mode |
| ivl_reload | input | IVL_W | Interval period in clock cycles |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selected for writing |
| wr_data | input | WEEK_W | Value to load |
| rd_sel | input | 3 | Field selected for reading |
| rd_data | output | WEEK_W | Selected field value |
| tick_irq | output | 1 | One-cycle interrupt pulse |
| week_ovf | output | 1 | Sticky week-overflow flag |

## Verification
A field write and the expiry of the one-second prescaler can fall in the same clock cycle. When they do, the write must win: the field is loaded, no second passes and no interrupt fires. The bench counts cycles after a write so that it can place a second write exactly on the edge where the prescaler would expire. It then checks that the seconds field holds the written value and `tick_irq` stays low. It also checks that the next step comes only after another full period.

// File: rtl/wtc_pkg.sv
// Shared definitions for the week-day-time counter: field codes and per-field moduli.
package wtc_pkg;
    localparam int unsigned NFIELD = 5;

    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_DAY  = 3'd3,
        F_WEEK = 3'd4
    } field_t;

    // Modulus of field i; the top field spans the full week width.
    function automatic int unsigned field_mod(input int unsigned i, input int unsigned week_w);
        case (i)
            0, 1:    return 60;
            2:       return 24;
            3:       return 7;
            default: return 32'd1 << week_w;
        endcase
    endfunction
endpackage

// File: rtl/wtc_prescaler.sv
// One-second prescaler. Counts sub_tick pulses (src_main=0) or clk cycles
// (src_main=1) and flags the step that completes a second.
// Assumes sub_tick is already synchronous to clk. clr restarts the period and
// suppresses the step in that cycle.
module wtc_prescaler #(
    parameter int unsigned SUB_DIV  = 32768,
    parameter int unsigned MAIN_DIV = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic src_main,
    input  logic sub_tick,
    input  logic clr,
    output logic sec_pulse
);
    localparam int unsigned MAXDIV = (SUB_DIV > MAIN_DIV) ? SUB_DIV : MAIN_DIV;
    localparam int unsigned PW     = $clog2(MAXDIV + 1);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] lim_m1;
    logic          step;

    // Select the terminal count and qualify a counting step.
    always_comb begin
        lim_m1    = src_main ? PW'(MAIN_DIV - 1) : PW'(SUB_DIV - 1);
        step      = en && (src_main || sub_tick);
        sec_pulse = step && !clr && (cnt_q >= lim_m1);
    end

    // Advance, restart on completion, or clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || sec_pulse) cnt_q <= '0;
        else if (step)                  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wtc_mod_counter.sv
// Modulo-MOD counter with load. A load above MOD-1 stores 0. carry is high
// when an increment wraps the counter. Load has priority over increment.
module wtc_mod_counter #(
    parameter int unsigned MOD = 60,
    parameter int unsigned DW  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          ld,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] value,
    output logic          carry
);
    localparam int unsigned W = $clog2(MOD);

    logic [W-1:0] cnt_q;

    // Wrap detection on an increment at the top value.
    assign carry = inc && !ld && (cnt_q == W'(MOD - 1));
    assign value = DW'(cnt_q);

    // Load, wrap or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (ld)                      cnt_q <= (32'(ld_val) < 32'(MOD)) ? ld_val[W-1:0] : '0;
        else if (carry)                   cnt_q <= '0;
        else if (inc)                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wtc_interval.sv
// Interval timer on the main clock. expire pulses once every `reload` enabled
// cycles (0 treated as 1). The count restarts while disabled or on clr.
module wtc_interval #(
    parameter int unsigned IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [IVL_W-1:0] reload,
    output logic             expire
);
    logic [IVL_W-1:0] cnt_q;
    logic [IVL_W-1:0] lim_m1;

    // Terminal count, with a zero reload behaving as one.
    always_comb begin
        lim_m1 = (reload == '0) ? '0 : reload - 1'b1;
        expire = en && !clr && (cnt_q >= lim_m1);
    end

    // Count enabled cycles, restarting on expiry, disable or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr || expire) cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/weektime_counter.sv
// Week-day-time counter top. Prescaler -> cascade of five modulo counters
// (sec, min, hour, day, week), plus an interval timer sharing the interrupt.
// Assumes all inputs are synchronous to clk; writes take effect at the edge.
module weektime_counter
    import wtc_pkg::*;
#(
    parameter int unsigned SUB_DIV  = 32768,
    parameter int unsigned MAIN_DIV = 1000000,
    parameter int unsigned WEEK_W   = 12,
    parameter int unsigned IVL_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              src_main,
    input  logic              sub_tick,
    input  logic              ivl_mode,
    input  logic [IVL_W-1:0]  ivl_reload,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [WEEK_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    output logic [WEEK_W-1:0] rd_data,
    output logic              tick_irq,
    output logic              week_ovf
);
    logic              sec_pulse;
    logic              ivl_exp;
    logic [NFIELD-1:0] stage_inc;
    logic [NFIELD-1:0] stage_carry;
    logic [WEEK_W-1:0] fld [NFIELD];
    logic              irq_q;
    logic              ovf_q;

    wtc_prescaler #(.SUB_DIV(SUB_DIV), .MAIN_DIV(MAIN_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_en && !ivl_mode),
        .src_main (src_main),
        .sub_tick (sub_tick),
        .clr      (wr_en),
        .sec_pulse(sec_pulse)
    );

    wtc_interval #(.IVL_W(IVL_W)) u_ivl (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_en && ivl_mode),
        .clr   (wr_en),
        .reload(ivl_reload),
        .expire(ivl_exp)
    );

    // Cascade: each stage steps on the carry of the one below.
    for (genvar i = 0; i < NFIELD; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stage_inc[i] = sec_pulse;
        end else begin : g_next
            assign stage_inc[i] = stage_carry[i-1];
        end
        wtc_mod_counter #(.MOD(field_mod(i, WEEK_W)), .DW(WEEK_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (stage_inc[i]),
            .ld    (wr_en && (wr_sel == 3'(i))),
            .ld_val(wr_data),
            .value (fld[i]),
            .carry (stage_carry[i])
        );
    end

    // Read-back multiplexer; undefined codes read zero.
    always_comb begin
        rd_data = '0;
        if (rd_sel < 3'(NFIELD)) rd_data = fld[rd_sel];
    end

    // Interrupt pulse register and sticky week overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            irq_q <= sec_pulse || ivl_exp;
            if (wr_en && wr_sel == F_WEEK)   ovf_q <= 1'b0;
            else if (stage_carry[NFIELD-1])  ovf_q <= 1'b1;
        end
    end

    assign tick_irq = irq_q;
    assign week_ovf = ovf_q;
endmodule

// Checker for weektime_counter: range, priority, stickiness and idle properties.
module weektime_counter_chk #(
    parameter int unsigned WEEK_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic              tick_irq,
    input logic              week_ovf,
    input logic [WEEK_W-1:0] f_sec,
    input logic [WEEK_W-1:0] f_min,
    input logic [WEEK_W-1:0] f_hour,
    input logic [WEEK_W-1:0] f_day,
    input logic [WEEK_W-1:0] f_week,
    input logic              week_carry
);
    p_field_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (f_sec < 60) && (f_min < 60) && (f_hour < 24) && (f_day < 7));

    p_write_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tick_irq);

    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (week_ovf && !(wr_en && wr_sel == 3'd4)) |=> week_ovf);

    p_week_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        week_carry |=> (f_week == '0) && week_ovf);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> ($stable(f_sec) && $stable(f_min) && $stable(f_hour)
                                 && $stable(f_day) && $stable(f_week) && !tick_irq));
endmodule

bind weektime_counter weektime_counter_chk #(.WEEK_W(WEEK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .tick_irq  (tick_irq),
    .week_ovf  (week_ovf),
    .f_sec     (fld[0]),
    .f_min     (fld[1]),
    .f_hour    (fld[2]),
    .f_day     (fld[3]),
    .f_week    (fld[4]),
    .week_carry(stage_carry[4])
);

// File: tb/weektime_counter_tb.sv
`timescale 1ns/1ps
module weektime_counter_tb;
    localparam int unsigned SUB_DIV  = 4;
    localparam int unsigned MAIN_DIV = 3;
    localparam int unsigned WEEK_W   = 12;
    localparam int unsigned IVL_W    = 8;
    localparam int NV = 6;
    // {sec, min, hour, day, week, seconds to run, exp sec, min, hour, day, week}
    localparam int VEC [NV][11] = '{
        '{ 0,  0,  0, 0,   0,  1,  1, 0,  0, 0,   0},
        '{58,  0,  0, 0,   0,  3,  1, 1,  0, 0,   0},
        '{59, 59, 23, 6,   7,  1,  0, 0,  0, 0,   8},
        '{59, 59, 22, 3,   0,  1,  0, 0, 23, 3,   0},
        '{70,  0,  0, 0,   0,  2,  2, 0,  0, 0,   0},
        '{30, 59,  5, 6, 100, 30,  0, 0,  6, 6, 100}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 1'b0;
    logic              src_main = 1'b1;
    logic              sub_tick = 1'b0;
    logic              ivl_mode = 1'b0;
    logic [IVL_W-1:0]  ivl_reload = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_sel = '0;
    logic [WEEK_W-1:0] wr_data = '0;
    logic [2:0]        rd_sel = '0;
    logic [WEEK_W-1:0] rd_data;
    logic              tick_irq;
    logic              week_ovf;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    weektime_counter #(.SUB_DIV(SUB_DIV), .MAIN_DIV(MAIN_DIV), .WEEK_W(WEEK_W), .IVL_W(IVL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_main(src_main), .sub_tick(sub_tick),
        .ivl_mode(ivl_mode), .ivl_reload(ivl_reload), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .tick_irq(tick_irq),
        .week_ovf(week_ovf)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int sel, input int val);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = WEEK_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int rd(input int sel);
        return 0;
    endfunction

    task automatic rdf(input int sel, output int val);
        rd_sel = 3'(sel);
        #0.1;
        val = int'(rd_data);
    endtask

    task automatic chk_all(input string tag, input int s, input int m, input int h, input int d, input int w);
        int v;
        rdf(0, v); chk({tag, " sec"}, v, s);
        rdf(1, v); chk({tag, " min"}, v, m);
        rdf(2, v); chk({tag, " hour"}, v, h);
        rdf(3, v); chk({tag, " day"}, v, d);
        rdf(4, v); chk({tag, " week"}, v, w);
    endtask

    task automatic load_all(input int s, input int m, input int h, input int d, input int w);
        wr(0, s); wr(1, m); wr(2, h); wr(3, d); wr(4, w);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R10 reset state
        chk_all("R10 reset", 0, 0, 0, 0, 0);
        chk("R10 irq", int'(tick_irq), 0);
        chk("R10 ovf", int'(week_ovf), 0);
        rdf(6, v); chk("R11 unused code", v, 0);

        // R9 idle: run off, nothing moves
        cyc(20);
        chk_all("R9 idle", 0, 0, 0, 0, 0);

        // Vector table (R2 R3 R5): main-clock source
        run_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            load_all(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
            cyc(VEC[i][5] * MAIN_DIV);
            chk_all($sformatf("R3 vec%0d", i), VEC[i][6], VEC[i][7], VEC[i][8], VEC[i][9], VEC[i][10]);
        end

        // R7 irq pulse: appears with the advanced value, lasts one cycle
        load_all(10, 0, 0, 0, 0);
        cyc(MAIN_DIV - 1);
        rdf(0, v); chk("R6 full period", v, 10);
        chk("R7 irq before", int'(tick_irq), 0);
        cyc(1);
        rdf(0, v); chk("R7 advance", v, 11);
        chk("R7 irq high", int'(tick_irq), 1);
        cyc(1);
        chk("R7 irq one cycle", int'(tick_irq), 0);

        // R6 write coinciding with prescaler expiry
        load_all(20, 0, 0, 0, 0);
        cyc(MAIN_DIV - 1);
        wr(0, 40);
        rdf(0, v); chk("R6 write wins", v, 40);
        chk("R6 no irq on write", int'(tick_irq), 0);
        cyc(MAIN_DIV - 1);
        rdf(0, v); chk("R6 restart", v, 40);
        cyc(1);
        rdf(0, v); chk("R6 next second", v, 41);

        // R4 week overflow and stickiness
        load_all(59, 59, 23, 6, 4095);
        chk("R4 ovf before", int'(week_ovf), 0);
        cyc(MAIN_DIV);
        chk_all("R4 wrap", 0, 0, 0, 0, 0);
        chk("R4 ovf set", int'(week_ovf), 1);
        wr(0, 5);
        cyc(MAIN_DIV * 2);
        chk("R4 ovf sticky", int'(week_ovf), 1);
        wr(4, 9);
        chk("R4 ovf cleared", int'(week_ovf), 0);
        rdf(4, v); chk("R5 week load", v, 9);

        // R1 subclock source
        src_main = 1'b0;
        load_all(0, 0, 0, 0, 0);
        cyc(20);
        rdf(0, v); chk("R1 no ticks", v, 0);
        for (int k = 0; k < int'(SUB_DIV) - 1; k++) begin
            sub_tick = 1'b1; cyc(1); sub_tick = 1'b0; cyc(1);
        end
        rdf(0, v); chk("R1 before last tick", v, 0);
        sub_tick = 1'b1; cyc(1); sub_tick = 1'b0;
        rdf(0, v); chk("R1 one second", v, 1);
        src_main = 1'b1;

        // R8 interval mode
        load_all(7, 3, 2, 1, 0);
        ivl_reload = 8'd5;
        ivl_mode = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            cyc(1);
            chk($sformatf("R8 irq cycle %0d", k), int'(tick_irq), (k % 5 == 0) ? 1 : 0);
        end
        chk_all("R8 hold", 7, 3, 2, 1, 0);
        ivl_reload = 8'd0;
        cyc(2);
        chk("R8 zero reload", int'(tick_irq), 1);
        ivl_mode = 1'b0;

        // R9 run off after activity
        run_en = 1'b0;
        load_all(1, 2, 3, 4, 5);
        cyc(MAIN_DIV * 4);
        chk_all("R9 stopped", 1, 2, 3, 4, 5);
        chk("R9 irq low", int'(tick_irq), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule